// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Sequencer

This block is the fetch and operand-steering controller of a small non-pipelined 8-bit processor. Code and data share one byte-wide RAM with no cache, and instructions are one to three bytes long. The sequencer reads an opcode byte, decodes from it how many operand bytes follow, and then reads each operand byte in turn. Every byte read uses the same three-step pattern: copy the program counter into the memory address register and advance the counter, present that address to memory, then take the returned byte one clock later.

Only the opcode is kept. Operand bytes go straight to the unit that uses them. An add-immediate operand goes to the right input of the ALU, where it is added to accumulator C and the sum is written back to C. A jump takes a low byte and then a high byte, and these become the new program counter. Each instruction completes before the next opcode read begins.

The memory port is a plain fixed-latency read port rather than a valid/ready stream. A read is requested for exactly one cycle, the RAM must return the byte on the next cycle, and the RAM has no way to stall the sequencer.

Top module: `fetch_seq`

## Requirements
- R1: While synchronous reset is high, `pc_o` and `acc_o` read 0 and `mem_rd` is low. The first memory read after reset is from address 0.
- R2: Each byte read takes three cycles: address load, request and take. `mem_rd` is high for exactly one cycle per byte, `mem_addr` shows that byte's address, and the bytes of one instruction come from consecutive addresses.
- R3: Opcode 0x01 is two bytes long and opcode 0x02 is three bytes long. Every other opcode is one byte long. An instruction of N bytes takes 3×N cycles, and `instr_done` pulses once, in its last cycle. The next opcode read starts only after that pulse.
- R4: Add-immediate (0x01) sets C to the old C plus the operand byte, modulo 256.
- R5: Jump (0x02) reads the low byte first and the high byte second. It loads the program counter with {high[5:0], low}. Bits 7:6 of the high byte have no effect.
- R6: `opcode_o` changes only when an opcode byte is taken. Operand bytes never change it.
- R7: Opcodes other than 0x01 leave C unchanged.
- R8: The program counter wraps from 0x3FFF to 0x0000. This applies to opcode and operand reads alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_rd | output | 1 | Read request to the RAM, one cycle per byte |
| mem_addr | output | 14 | Read address (memory address register) |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| pc_o | output | 14 | Program counter |
| acc_o | output | 8 | Accumulator C |
| opcode_o | output | 8 | Latched opcode of the current instruction |
| instr_done | output | 1 | Pulses in the final cycle of each instruction |

## Verification
The bench targets the length decode, the add-immediate overflow and the jump address. If the length decode were wrong, the cycle counts would not match and later operands would be run as opcodes. If the carry handling were wrong, the accumulator would not wrap modulo 256. If the jump used the whole high byte, or assembled the bytes in the wrong order, the next read address would be wrong. The bench also runs an add-immediate placed at 0x3FFF, so its operand has to come from address 0. A counter that fails to wrap, or that latches an operand as an opcode, shows up there as the wrong read address or the wrong `opcode_o`.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  typedef enum logic [1:0] {
    ST_LOAD = 2'd0,
    ST_REQ  = 2'd1,
    ST_TAKE = 2'd2
  } step_t;

  typedef enum logic {
    ALU_PASS = 1'b0,
    ALU_ADD  = 1'b1
  } alu_op_t;

  localparam logic [7:0] OP_ADDI = 8'h01;
  localparam logic [7:0] OP_JMP  = 8'h02;

  // Number of operand bytes that follow a given opcode
  function automatic logic [1:0] operand_count(input logic [7:0] op);
    case (op)
      OP_ADDI: operand_count = 2'd1;
      OP_JMP:  operand_count = 2'd2;
      default: operand_count = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] rdata,
  output logic              mar_load,
  output logic              rd_req,
  output logic              acc_we,
  output alu_op_t           alu_op,
  output logic              jlo_we,
  output logic              jhi_we,
  output logic [DATA_W-1:0] opcode,
  output logic              done
);

  step_t             step;
  logic [1:0]        idx;
  logic [DATA_W-1:0] opcode_q;
  logic              take;
  logic              take_opc;
  logic              last_byte;
  logic [1:0]        need;

  assign take     = (step == ST_TAKE);
  assign take_opc = take && (idx == 2'd0);
  assign need     = take_opc ? operand_count(rdata[7:0]) : operand_count(opcode_q[7:0]);
  assign last_byte = (idx == need);

  assign mar_load = (step == ST_LOAD);
  assign rd_req   = (step == ST_REQ);
  assign done     = take && last_byte;
  assign acc_we   = take && (idx == 2'd1) && (opcode_q[7:0] == OP_ADDI);
  assign alu_op   = acc_we ? ALU_ADD : ALU_PASS;
  assign jlo_we   = take && (idx == 2'd1) && (opcode_q[7:0] == OP_JMP);
  assign jhi_we   = take && (idx == 2'd2) && (opcode_q[7:0] == OP_JMP);
  assign opcode   = opcode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      step     <= ST_LOAD;
      idx      <= 2'd0;
      opcode_q <= '0;
    end else begin
      case (step)
        ST_LOAD: step <= ST_REQ;
        ST_REQ:  step <= ST_TAKE;
        default: begin
          step <= ST_LOAD;
          if (take_opc) opcode_q <= rdata;
          idx <= last_byte ? 2'd0 : idx + 2'd1;
        end
      endcase
    end
  end

  // R2
  rd_single_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);

  // R6
  opcode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !take_opc |=> $stable(opcode_q));

  // R3
  done_in_take_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> mar_load);

endmodule

// File: rtl/fetch_pc.sv
module fetch_pc #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mar_load,
  input  logic              jlo_we,
  input  logic              jhi_we,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] mar
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic [DATA_W-1:0] jlo;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      mar <= '0;
      jlo <= '0;
    end else begin
      if (mar_load) begin
        mar <= pc;
        pc  <= pc + ADDR_W'(1);
      end
      if (jlo_we) jlo <= rdata;
      if (jhi_we) pc <= {rdata[HI_W-1:0], jlo};
    end
  end

  // R2
  mar_from_pc_chk: assert property (@(posedge clk) disable iff (rst)
    mar_load |=> (mar == $past(pc)));

  // R8
  no_load_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(mar_load && jhi_we));

endmodule

// File: rtl/fetch_alu_c.sv
module fetch_alu_c
  import fetch_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  alu_op_t           op,
  input  logic [DATA_W-1:0] right,
  output logic [DATA_W-1:0] acc
);

  logic [DATA_W-1:0] result;

  always_comb begin
    case (op)
      ALU_ADD: result = acc + right;
      default: result = acc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else if (we) acc <= result;
  end

  // R7
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(acc));

endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
  import fetch_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [DATA_W-1:0] opcode_o,
  output logic              instr_done
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic    mar_load;
  logic    acc_we;
  logic    jlo_we;
  logic    jhi_we;
  alu_op_t alu_op;

  fetch_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .rdata(mem_rdata),
    .mar_load(mar_load), .rd_req(mem_rd), .acc_we(acc_we), .alu_op(alu_op),
    .jlo_we(jlo_we), .jhi_we(jhi_we), .opcode(opcode_o), .done(instr_done)
  );

  fetch_pc #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pc (
    .clk(clk), .rst(rst), .mar_load(mar_load), .jlo_we(jlo_we),
    .jhi_we(jhi_we), .rdata(mem_rdata), .pc(pc_o), .mar(mem_addr)
  );

  fetch_alu_c #(.DATA_W(DATA_W)) u_alu (
    .clk(clk), .rst(rst), .we(acc_we), .op(alu_op),
    .right(mem_rdata), .acc(acc_o)
  );

  // R5
  jump_hi_chk: assert property (@(posedge clk) disable iff (rst)
    jhi_we |=> (pc_o[ADDR_W-1:DATA_W] == $past(mem_rdata[HI_W-1:0])));

  // R4
  addi_sum_chk: assert property (@(posedge clk) disable iff (rst)
    acc_we |=> (acc_o == DATA_W'($past(acc_o) + $past(mem_rdata))));

endmodule

// File: tb/fetch_seq_bench.sv
module fetch_seq_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_rd;
  logic [13:0] mem_addr;
  logic [7:0]  mem_rdata = 8'h00;
  logic [13:0] pc_o;
  logic [7:0]  acc_o;
  logic [7:0]  opcode_o;
  logic        instr_done;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  logic [7:0]  lo_mem [0:255];
  logic [7:0]  hi_mem [0:255];
  logic [13:0] addr_log [0:3];
  int          n_reads;
  int          icyc;

  always #5 clk = ~clk;

  fetch_seq u_fetch_seq (
    .clk(clk), .rst(rst), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .pc_o(pc_o), .acc_o(acc_o),
    .opcode_o(opcode_o), .instr_done(instr_done)
  );

  function automatic logic [7:0] byte_at(input logic [13:0] a);
    if (a < 14'h0100) return lo_mem[a[7:0]];
    if (a >= 14'h3F00) return hi_mem[a[7:0]];
    return 8'h00;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= byte_at(mem_addr);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests = n_tests + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) begin
      lo_mem[i] = 8'h00;
      hi_mem[i] = 8'h00;
    end
  endtask

  // Ends at a negedge in the first address-load cycle after reset
  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(pc_o == 14'h0, "R1 pc in reset", pc_o, 0);
    chk(acc_o == 8'h0, "R1 acc in reset", acc_o, 0);
    chk(mem_rd == 1'b0, "R1 mem_rd in reset", mem_rd, 0);
    rst = 1'b0;
  endtask

  // Starts at a negedge of an address-load cycle; ends at the next one
  task automatic run_instr();
    icyc = 1;
    n_reads = 0;
    forever begin
      @(negedge clk);
      icyc++;
      if (mem_rd) begin
        if (n_reads < 4) addr_log[n_reads] = mem_addr;
        n_reads++;
      end
      if (instr_done || icyc > 20) break;
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    clear_mem();
    do_reset();
    run_instr();
    chk(addr_log[0] == 14'h0, "R1 first read address", addr_log[0], 0);
  endtask

  task automatic t_nop();
    clear_mem();
    do_reset();
    for (int i = 0; i < 3; i++) begin
      run_instr();
      chk(icyc == 3, "R3 nop cycles", icyc, 3);
      chk(n_reads == 1, "R2 nop read count", n_reads, 1);
      chk(addr_log[0] == 14'(i), "R2 nop address", addr_log[0], i);
      chk(pc_o == 14'(i + 1), "R2 nop pc", pc_o, i + 1);
    end
  endtask

  task automatic t_addi();
    clear_mem();
    lo_mem[0] = 8'h01; lo_mem[1] = 8'h05;
    lo_mem[2] = 8'h01; lo_mem[3] = 8'hFE;
    lo_mem[4] = 8'h01; lo_mem[5] = 8'h20;
    do_reset();
    run_instr();
    chk(icyc == 6, "R3 addi cycles", icyc, 6);
    chk(n_reads == 2 && addr_log[1] == 14'h1, "R2 addi operand address", addr_log[1], 1);
    chk(acc_o == 8'h05, "R4 addi first", acc_o, 8'h05);
    chk(opcode_o == 8'h01, "R6 opcode kept over operand", opcode_o, 8'h01);
    run_instr();
    chk(acc_o == 8'h03, "R4 addi wrap", acc_o, 8'h03);
    chk(opcode_o == 8'h01, "R6 opcode not operand FE", opcode_o, 8'h01);
    run_instr();
    chk(acc_o == 8'h23, "R4 addi third", acc_o, 8'h23);
    chk(pc_o == 14'h6, "R2 pc after addi", pc_o, 6);
    run_instr();
    chk(acc_o == 8'h23, "R7 nop keeps acc", acc_o, 8'h23);
    chk(opcode_o == 8'h00, "R6 opcode nop", opcode_o, 0);
  endtask

  task automatic t_unknown();
    clear_mem();
    lo_mem[0] = 8'h77; lo_mem[1] = 8'hFF;
    lo_mem[2] = 8'h01; lo_mem[3] = 8'h10;
    do_reset();
    run_instr();
    chk(icyc == 3, "R3 unknown length", icyc, 3);
    chk(acc_o == 8'h00, "R7 unknown 77 acc", acc_o, 0);
    chk(pc_o == 14'h1, "R3 unknown pc", pc_o, 1);
    run_instr();
    chk(icyc == 3 && acc_o == 8'h00, "R7 unknown FF acc", acc_o, 0);
    run_instr();
    chk(acc_o == 8'h10, "R4 addi after unknown", acc_o, 8'h10);
  endtask

  task automatic t_jump();
    clear_mem();
    lo_mem[0] = 8'h02; lo_mem[1] = 8'h34; lo_mem[2] = 8'hD2;
    do_reset();
    run_instr();
    chk(icyc == 9, "R3 jump cycles", icyc, 9);
    chk(n_reads == 3 && addr_log[2] == 14'h2, "R2 jump reads", addr_log[2], 2);
    chk(pc_o == 14'h1234, "R5 jump target high bits masked", pc_o, 14'h1234);
    chk(opcode_o == 8'h02, "R6 opcode jump", opcode_o, 8'h02);
    run_instr();
    chk(addr_log[0] == 14'h1234, "R5 read at target", addr_log[0], 14'h1234);
  endtask

  task automatic t_wrap();
    clear_mem();
    lo_mem[0] = 8'h02; lo_mem[1] = 8'hFF; lo_mem[2] = 8'hFF;
    hi_mem[8'hFF] = 8'h01;
    do_reset();
    run_instr();
    chk(pc_o == 14'h3FFF, "R5 jump to top", pc_o, 14'h3FFF);
    run_instr();
    chk(addr_log[0] == 14'h3FFF, "R8 opcode at top", addr_log[0], 14'h3FFF);
    chk(addr_log[1] == 14'h0000, "R8 operand wraps to 0", addr_log[1], 0);
    chk(acc_o == 8'h02, "R4 operand from address 0", acc_o, 8'h02);
    chk(pc_o == 14'h0001, "R8 pc after wrap", pc_o, 1);
  endtask

  initial begin
    t_reset();
    t_nop();
    t_addi();
    t_unknown();
    t_jump();
    t_wrap();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule